// File: doc/BRIEF.md
# Dynamic cache way sizing controller

This controller decides how many ways of a set-associative second-level cache stay enabled while a two-core package moves in and out of its deepest sleep state. Each time the package enters deep sleep, it may give up a programmable number of ways. It does so only when several things hold at once: the other core already sits in its deepest C-state, the enhanced voltage sub-state is allowed, shrink prevention is off, the package has not stayed in the normal running state for too long, and the bus-to-core speed ratio is low enough. A ratio of zero tells the controller to leave the ratio out of the decision.

On wake-up the controller brings the cache back to exactly two ways. It does not restore full size at once. Events that argue for a full cache are remembered: a high speed ratio, an expired residency timer, or the other core asking for a shallow C-state. The full expansion is then carried out at the next interrupt. The ways are removed and restored through request/done handshakes with an external flush engine and an external invalidate engine, and the enabled-way count moves only when the done pulse arrives.

The state machine has three states. ST_IDLE waits for events. ST_FLUSH holds a flush/disable request until `flush_done`. ST_INVAL holds an invalidate request until `inval_done`. The transitions are:
- IDLE→INVAL on a wake with fewer than two ways.
- IDLE→INVAL on an interrupt with latched growth demand and fewer than the full count of ways.
- IDLE→FLUSH on an accepted deep-sleep entry that removes at least one way.
- FLUSH→IDLE on `flush_done`.
- INVAL→IDLE on `inval_done`.

Top module: `cache_way_sizer`

## Requirements
- R1: After reset `ways_en` equals NUM_WAYS and both `flush_req` and `inval_req` are low.
- R2: An accepted deep-sleep entry with step s removes ways: the new count is `ways_en - s`, clamped at 0. The flush request names the lowest removed way in `flush_first` (equal to the new count) and the number removed in `flush_count`. A step of 0, or a count already at 0, issues no flush.
- R3: An entry is accepted for shrinking only when `enh_en` is 1, `shrink_block` is 0, and `other_cstate` is 4 (the C4 encoding; 0..3 mean C0..C3).
- R4: With `ratio` nonzero, shrinking needs `ratio < shrink_thr`, and `ratio > shrink_thr` raises growth demand. With `ratio` equal to 0 the ratio neither allows nor forbids anything.
- R5: The residency timer counts the cycles with `pkg_normal` high and holds otherwise. It expires at C0_LIMIT counts, and once expired it blocks shrinking and raises growth demand. Any deep-sleep entry seen in ST_IDLE clears it.
- R6: A wake with `ways_en < 2` requests invalidation of ways `ways_en`..1 and leaves 2 ways enabled. A wake with 2 or more ways enabled does nothing.
- R7: Growth demand is latched. An interrupt with demand latched and `ways_en < NUM_WAYS` requests invalidation of ways `ways_en`..NUM_WAYS-1 and ends at NUM_WAYS. An interrupt without demand does nothing.
- R8: `other_cstate` of 1, 2 or 3 raises growth demand.
- R9: A request stays high until its done pulse, and `ways_en` changes on the cycle after done. Entry, wake and interrupt events that arrive while a request is pending are dropped.
- R10: When events coincide in ST_IDLE, wake takes precedence over interrupt, and interrupt takes precedence over entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_entry | input | 1 | Pulse: package enters deep sleep |
| wake | input | 1 | Pulse: stop-clock released, first core wakes |
| intr | input | 1 | Pulse: interrupt event |
| pkg_normal | input | 1 | Package is in the normal running state |
| other_cstate | input | 3 | C-state requested by the other core (0..4) |
| enh_en | input | 1 | Enhanced voltage sub-state allowed |
| shrink_block | input | 1 | Shrink prevention |
| ratio | input | RATIO_W | Bus-to-core speed ratio, 0 = ignore |
| shrink_thr | input | RATIO_W | Shrink threshold |
| shrink_step | input | WAY_W | Ways removed per entry |
| flush_done | input | 1 | Flush engine finished |
| inval_done | input | 1 | Invalidate engine finished |
| ways_en | output | WAY_W | Enabled-way count |
| flush_req | output | 1 | Flush/disable request |
| flush_first | output | WAY_W | Lowest way being removed |
| flush_count | output | WAY_W | Number of ways being removed |
| inval_req | output | 1 | Invalidate request |
| inval_first | output | WAY_W | Lowest way being re-enabled |
| inval_count | output | WAY_W | Number of ways being re-enabled |

## Verification
The bench sweeps every combination of enable, other-core C-state, prevention, and a 4×4 grid of ratio and threshold, including ratio equal to threshold and ratio zero. A design that mixes up the zero-ratio rule or the strict comparisons would shrink or grow in the wrong cells. It also sweeps the step from 0 to 15 on 8 ways, where a missing clamp would wrap the way count below zero, and follows each result with a wake, to catch a wake that fails to restore exactly two ways or that touches a larger cache. The timer is probed at one count below its limit and well past it, which exposes an off-by-one or a timer that is never cleared. Events injected while a request is pending and events that coincide expose a design that accepts overlapping work or gets the precedence order wrong.

// File: rtl/cws_pkg.sv
package cws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_INVAL = 2'd2
    } cws_state_e;

    localparam logic [2:0] CST_C1 = 3'd1;
    localparam logic [2:0] CST_C3 = 3'd3;
    localparam logic [2:0] CST_C4 = 3'd4;

endpackage

// File: rtl/cws_c0_timer.sv
module cws_c0_timer #(
    parameter int C0_LIMIT = 1000,
    localparam int TW = $clog2(C0_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic normal,
    input  logic clear,
    output logic expired
);

    logic [TW-1:0] count_q;

    assign expired = (count_q == TW'(C0_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (normal && !expired) begin
            count_q <= count_q + 1'b1;
        end
    end

    assert_timer_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TW'(C0_LIMIT));

    assert_timer_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !expired);

endmodule

// File: rtl/cws_policy.sv
module cws_policy
    import cws_pkg::*;
#(
    parameter int RATIO_W = 6
) (
    input  logic               enh_en,
    input  logic [2:0]         other_cstate,
    input  logic               shrink_block,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] shrink_thr,
    input  logic               expired,
    output logic               shrink_ok,
    output logic               grow_demand
);

    logic ratio_on;
    logic ratio_low;
    logic ratio_high;
    logic other_deep;
    logic other_shallow;

    always_comb begin
        ratio_on      = (ratio != '0);
        ratio_low     = !ratio_on || (ratio < shrink_thr);
        ratio_high    = ratio_on && (ratio > shrink_thr);
        other_deep    = (other_cstate == CST_C4);
        other_shallow = (other_cstate >= CST_C1) && (other_cstate <= CST_C3);
        shrink_ok     = enh_en && !shrink_block && other_deep && !expired && ratio_low;
        grow_demand   = ratio_high || expired || other_shallow;
    end

endmodule

// File: rtl/cws_way_fsm.sv
module cws_way_fsm
    import cws_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W = $clog2(NUM_WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_entry,
    input  logic             wake,
    input  logic             intr,
    input  logic             shrink_ok,
    input  logic             grow_demand,
    input  logic [WAY_W-1:0] shrink_step,
    input  logic             flush_done,
    input  logic             inval_done,
    output logic             timer_clear,
    output logic [WAY_W-1:0] ways_en,
    output logic             flush_req,
    output logic [WAY_W-1:0] flush_first,
    output logic [WAY_W-1:0] flush_count,
    output logic             inval_req,
    output logic [WAY_W-1:0] inval_first,
    output logic [WAY_W-1:0] inval_count
);

    localparam logic [WAY_W-1:0] FULL = WAY_W'(NUM_WAYS);
    localparam logic [WAY_W-1:0] WAKE_WAYS = WAY_W'(2);

    cws_state_e       state_q, state_d;
    logic [WAY_W-1:0] ways_q, ways_d;
    logic [WAY_W-1:0] lo_q, lo_d;
    logic [WAY_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    logic [WAY_W-1:0] shrunk;

    // Next-state and datapath decisions
    always_comb begin
        state_d     = state_q;
        ways_d      = ways_q;
        lo_d        = lo_q;
        cnt_d       = cnt_q;
        pend_d      = pend_q | grow_demand;
        timer_clear = 1'b0;
        shrunk      = (ways_q > shrink_step) ? (ways_q - shrink_step) : '0;
        unique case (state_q)
            ST_IDLE: begin
                timer_clear = sleep_entry;
                if (wake && (ways_q < WAKE_WAYS)) begin
                    state_d = ST_INVAL;
                    lo_d    = ways_q;
                    cnt_d   = WAKE_WAYS - ways_q;
                end else if (intr && (pend_q || grow_demand)) begin
                    pend_d = 1'b0;
                    if (ways_q < FULL) begin
                        state_d = ST_INVAL;
                        lo_d    = ways_q;
                        cnt_d   = FULL - ways_q;
                    end
                end else if (sleep_entry && shrink_ok && (shrunk != ways_q)) begin
                    state_d = ST_FLUSH;
                    lo_d    = shrunk;
                    cnt_d   = ways_q - shrunk;
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    state_d = ST_IDLE;
                    ways_d  = lo_q;
                end
            end
            ST_INVAL: begin
                if (inval_done) begin
                    state_d = ST_IDLE;
                    ways_d  = lo_q + cnt_q;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ways_q  <= FULL;
            lo_q    <= '0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ways_q  <= ways_d;
            lo_q    <= lo_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        ways_en     = ways_q;
        flush_req   = 1'b0;
        flush_first = '0;
        flush_count = '0;
        inval_req   = 1'b0;
        inval_first = '0;
        inval_count = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FLUSH: begin
                flush_req   = 1'b1;
                flush_first = lo_q;
                flush_count = cnt_q;
            end
            ST_INVAL: begin
                inval_req   = 1'b1;
                inval_first = lo_q;
                inval_count = cnt_q;
            end
            default: ;
        endcase
    end

    assert_ways_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ways_en <= FULL);

    assert_no_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(shrink_ok && grow_demand));

    assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> (flush_req && $stable(ways_en)));

    assert_flush_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> (ways_en == $past(flush_first) && !flush_req));

    assert_wake_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && !inval_req && wake && (ways_en < WAKE_WAYS))
        |=> (inval_req && (inval_first + inval_count == WAKE_WAYS)));

    assert_inval_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_req && inval_done)
        |=> (ways_en == $past(inval_first) + $past(inval_count)));

endmodule

// File: rtl/cache_way_sizer.sv
module cache_way_sizer
    import cws_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int RATIO_W  = 6,
    parameter int C0_LIMIT = 1000,
    localparam int WAY_W   = $clog2(NUM_WAYS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_entry,
    input  logic               wake,
    input  logic               intr,
    input  logic               pkg_normal,
    input  logic [2:0]         other_cstate,
    input  logic               enh_en,
    input  logic               shrink_block,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RATIO_W-1:0] shrink_thr,
    input  logic [WAY_W-1:0]   shrink_step,
    input  logic               flush_done,
    input  logic               inval_done,
    output logic [WAY_W-1:0]   ways_en,
    output logic               flush_req,
    output logic [WAY_W-1:0]   flush_first,
    output logic [WAY_W-1:0]   flush_count,
    output logic               inval_req,
    output logic [WAY_W-1:0]   inval_first,
    output logic [WAY_W-1:0]   inval_count
);

    logic expired;
    logic timer_clear;
    logic shrink_ok;
    logic grow_demand;

    cws_c0_timer #(.C0_LIMIT(C0_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .normal  (pkg_normal),
        .clear   (timer_clear),
        .expired (expired)
    );

    cws_policy #(.RATIO_W(RATIO_W)) u_policy (
        .enh_en       (enh_en),
        .other_cstate (other_cstate),
        .shrink_block (shrink_block),
        .ratio        (ratio),
        .shrink_thr   (shrink_thr),
        .expired      (expired),
        .shrink_ok    (shrink_ok),
        .grow_demand  (grow_demand)
    );

    cws_way_fsm #(.NUM_WAYS(NUM_WAYS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_entry (sleep_entry),
        .wake        (wake),
        .intr        (intr),
        .shrink_ok   (shrink_ok),
        .grow_demand (grow_demand),
        .shrink_step (shrink_step),
        .flush_done  (flush_done),
        .inval_done  (inval_done),
        .timer_clear (timer_clear),
        .ways_en     (ways_en),
        .flush_req   (flush_req),
        .flush_first (flush_first),
        .flush_count (flush_count),
        .inval_req   (inval_req),
        .inval_first (inval_first),
        .inval_count (inval_count)
    );

    assert_block_no_shrink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shrink_block && !flush_req) |=> !flush_req);

    assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && inval_req));

endmodule

// File: tb/test_cache_way_sizer.sv
module test_cache_way_sizer;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int LIM = 20;
    localparam int WW = $clog2(NW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_entry = 0, wake = 0, intr = 0, pkg_normal = 0;
    logic [2:0] other_cstate = 3'd4;
    logic enh_en = 1, shrink_block = 0;
    logic [5:0] ratio = 0, shrink_thr = 0;
    logic [WW-1:0] shrink_step = 3;
    logic flush_done = 0, inval_done = 0;
    logic [WW-1:0] ways_en, flush_first, flush_count, inval_first, inval_count;
    logic flush_req, inval_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_way_sizer #(.NUM_WAYS(NW), .RATIO_W(6), .C0_LIMIT(LIM)) i_cache_way_sizer (
        .clk(clk), .rst_n(rst_n), .sleep_entry(sleep_entry), .wake(wake), .intr(intr),
        .pkg_normal(pkg_normal), .other_cstate(other_cstate), .enh_en(enh_en),
        .shrink_block(shrink_block), .ratio(ratio), .shrink_thr(shrink_thr),
        .shrink_step(shrink_step), .flush_done(flush_done), .inval_done(inval_done),
        .ways_en(ways_en), .flush_req(flush_req), .flush_first(flush_first),
        .flush_count(flush_count), .inval_req(inval_req), .inval_first(inval_first),
        .inval_count(inval_count)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 0;
        sleep_entry = 0; wake = 0; intr = 0; pkg_normal = 0;
        flush_done = 0; inval_done = 0;
        other_cstate = 3'd4; enh_en = 1; shrink_block = 0; ratio = 0; shrink_thr = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_entry();  sleep_entry = 1; @(negedge clk); sleep_entry = 0; endtask
    task automatic pulse_wake();   wake = 1;        @(negedge clk); wake = 0;        endtask
    task automatic pulse_intr();   intr = 1;        @(negedge clk); intr = 0;        endtask
    task automatic fdone();        flush_done = 1;  @(negedge clk); flush_done = 0;  endtask
    task automatic idone();        inval_done = 1;  @(negedge clk); inval_done = 0;  endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        reset_dut();
        check("R1 ways", int'(ways_en), NW);
        check("R1 flush_req", int'(flush_req), 0);
        check("R1 inval_req", int'(inval_req), 0);

        // R2 / R6 step sweep with clamp, followed by wake
        for (int s = 0; s < 16; s++) begin
            int nw;
            reset_dut();
            shrink_step = WW'(s);
            nw = (s >= NW) ? 0 : NW - s;
            pulse_entry();
            check("R2 flush_req", int'(flush_req), (nw != NW) ? 1 : 0);
            if (nw != NW) begin
                check("R2 flush_first", int'(flush_first), nw);
                check("R2 flush_count", int'(flush_count), NW - nw);
                fdone();
            end
            check("R2 ways", int'(ways_en), nw);
            pulse_wake();
            check("R6 inval_req", int'(inval_req), (nw < 2) ? 1 : 0);
            if (nw < 2) begin
                check("R6 inval_first", int'(inval_first), nw);
                check("R6 inval_count", int'(inval_count), 2 - nw);
                idone();
                check("R6 ways", int'(ways_en), 2);
            end else begin
                check("R6 ways kept", int'(ways_en), nw);
            end
        end

        // R3 / R4 / R7 / R8 condition sweep
        for (int e = 0; e < 2; e++)
        for (int o = 0; o < 5; o++)
        for (int b = 0; b < 2; b++)
        for (int r = 0; r < 4; r++)
        for (int t = 0; t < 4; t++) begin
            bit ok, grow;
            string tg, tgg;
            int cur;
            reset_dut();
            shrink_step = 3;
            pulse_entry();
            fdone();
            enh_en = e[0]; other_cstate = 3'(o); shrink_block = b[0];
            ratio = 6'(r); shrink_thr = 6'(t);
            @(negedge clk);
            ok   = e[0] && o == 4 && !b[0] && (r == 0 || r < t);
            grow = (r != 0 && r > t) || (o >= 1 && o <= 3);
            tg   = (e == 1 && o == 4 && b == 0) ? "R4" : "R3";
            tgg  = (o >= 1 && o <= 3) ? "R8" : ((r != 0 && r > t) ? "R4" : "R7");
            pulse_entry();
            check({tg, " shrink"}, int'(flush_req), ok ? 1 : 0);
            cur = 5;
            if (ok) begin
                fdone();
                cur = 2;
            end
            check({tg, " ways"}, int'(ways_en), cur);
            pulse_intr();
            check({tgg, " grow"}, int'(inval_req), grow ? 1 : 0);
            if (grow) begin
                check({tgg, " inval_first"}, int'(inval_first), cur);
                check({tgg, " inval_count"}, int'(inval_count), NW - cur);
                idone();
                check({tgg, " ways"}, int'(ways_en), NW);
            end else begin
                check({tgg, " ways kept"}, int'(ways_en), cur);
            end
        end

        // R5 residency timer
        reset_dut();
        shrink_step = 3;
        pulse_entry(); fdone();
        pkg_normal = 1;
        repeat (LIM - 1) @(negedge clk);
        pkg_normal = 0;
        pulse_entry();
        check("R5 below limit shrinks", int'(flush_req), 1);
        fdone();
        check("R5 ways", int'(ways_en), 2);
        pkg_normal = 1;
        repeat (LIM + 5) @(negedge clk);
        pkg_normal = 0;
        pulse_entry();
        check("R5 expired blocks", int'(flush_req), 0);
        pulse_intr();
        check("R5 expired grows", int'(inval_req), 1);
        check("R5 inval_first", int'(inval_first), 2);
        check("R5 inval_count", int'(inval_count), 6);
        idone();
        check("R5 ways full", int'(ways_en), NW);
        pulse_entry();
        check("R5 cleared by entry", int'(flush_req), 1);
        fdone();
        check("R5 ways after clear", int'(ways_en), 5);

        // R9 handshake hold and events dropped while busy
        reset_dut();
        shrink_step = 3;
        pulse_entry();
        repeat (4) @(negedge clk);
        check("R9 held", int'(flush_req), 1);
        check("R9 ways unchanged", int'(ways_en), NW);
        pulse_entry(); pulse_wake(); pulse_intr();
        check("R9 still one flush", int'(flush_count), 3);
        fdone();
        check("R9 ways", int'(ways_en), 5);
        check("R9 no follow-up flush", int'(flush_req), 0);
        check("R9 no follow-up inval", int'(inval_req), 0);

        // R10 precedence: wake wins over entry and interrupt
        reset_dut();
        shrink_step = 8;
        pulse_entry(); fdone();
        other_cstate = 3'd2;
        @(negedge clk);
        sleep_entry = 1; wake = 1; intr = 1;
        @(negedge clk);
        sleep_entry = 0; wake = 0; intr = 0;
        check("R10 wake wins", int'(inval_count), 2);
        idone();
        check("R10 ways", int'(ways_en), 2);
        pulse_intr();
        check("R10 latched demand kept", int'(inval_count), 6);
        idone();
        // interrupt beats entry
        shrink_step = 3; other_cstate = 3'd4;
        pulse_entry(); fdone();
        other_cstate = 3'd1;
        @(negedge clk);
        other_cstate = 3'd4;
        sleep_entry = 1; intr = 1;
        @(negedge clk);
        sleep_entry = 0; intr = 0;
        check("R10 intr over entry", int'(inval_req), 1);
        check("R10 no flush", int'(flush_req), 0);
        idone();
        check("R10 ways full", int'(ways_en), NW);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule